// File: doc/BRIEF.md
# External Instruction Fetch Sequencer

This block runs the bus cycle that reads one instruction byte from external program memory when the low address byte and the returned instruction share a single 8-bit bus. It raises an address-latch strobe while it drives the low address onto the shared bus, and keeps the low address on the bus briefly after the strobe falls. It then floats the bus and pulls an active-low read strobe so that the memory can drive the instruction, and it captures that byte on the last clock before the read strobe returns high. The high address byte stays on its own output for the whole cycle.

The block clock `clk_i` runs at twice the oscillator rate, so one clock equals half an oscillator period (0.5T). In standard mode the sequence advances once every two clocks. In double-speed mode it advances on every clock, which halves every interval without fractional counters. A fetch takes 6T in standard mode, so two fetches issued back to back fill a 12T machine cycle with two address-latch pulses. A request that arrives while a fetch is running waits in a one-entry slot. It starts on the clock right after the running fetch ends.

Top module: `fetch_seq`

## Requirements
- R1: While reset is held and after its release with no request, `ale_o`=0, `psen_no`=1, `bus_oe_o`=0 and `done_o`=0.
- R2: Counting clocks after the clock edge that accepts a request, `ale_o` is high for clocks 1 to 2L and low otherwise. L=2 in standard mode (2T) and L=1 in double-speed mode (1T).
- R3: `bus_oe_o` is high and `bus_o` carries the low address byte (address bits 7:0) from clock 1 through clock 3L. This holds the address L clocks (1T or 0.5T) past the fall of `ale_o`.
- R4: `psen_no` is low for clocks 3L+1 to 6L. It falls on the same clock in which `bus_oe_o` drops, and it is never low while `ale_o` or `bus_oe_o` is high.
- R5: `instr_o` takes the value of `bus_i` as sampled on clock 6L, the last clock with `psen_no` low. `done_o` is high for exactly one clock, clock 6L+1, and `instr_o` then holds until the next capture.
- R6: `addr_hi_o` carries address bits 15:8 from clock 1 through clock 6L. Changes on `addr_i` after acceptance have no effect.
- R7: A request that arrives during a fetch waits, and its fetch begins with `ale_o` high on clock 6L+1 of the running fetch. Consecutive standard-mode fetches therefore start 12 clocks (6T) apart.
- R8: The speed mode is taken from `dbl_speed_i` when a request is accepted. Changing `dbl_speed_i` during a fetch does not change that fetch's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, two cycles per oscillator period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Fetch request, sampled each clock |
| addr_i | input | 16 | Fetch address, taken with the request |
| dbl_speed_i | input | 1 | 1 selects double-speed timing |
| bus_i | input | 8 | Shared bus as seen at the pins |
| bus_o | output | 8 | Low address byte driven onto the shared bus |
| bus_oe_o | output | 1 | Shared bus drive enable |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_no | output | 1 | Program read strobe, active low |
| addr_hi_o | output | 8 | High address byte |
| instr_o | output | 8 | Last captured instruction byte |
| done_o | output | 1 | One-clock pulse after a capture |

## Verification
A step counter that is off by one moves a strobe edge by a whole step (one or two clocks). The clock-by-clock comparison of `ale_o`, `bus_oe_o` and `psen_no` shows this within the first fetch. A broken half-rate tick shows up in standard mode as intervals of the wrong length, or in double-speed mode as intervals that are not halved. A wrong capture point gives the filler value that the bench memory drives outside the strobe, and this appears at the `done_o` clock. A mishandled pending slot shows up either as a missing `ale_o` at clock 6L+1 or as the wrong address on the next fetch.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ALE    = 2'd1,
    ST_HOLD   = 2'd2,
    ST_STROBE = 2'd3
  } fetch_state_e;
endpackage

// File: rtl/fetch_tick_gen.sv
// Step enable: every clock in double-speed mode, every second clock otherwise.
module fetch_tick_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic dbl_i,
  output logic tick_o
);
  logic sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sub_q <= 1'b0;
    else if (!run_i || restart_i) sub_q <= 1'b0;
    else                        sub_q <= ~sub_q;
  end

  assign tick_o = dbl_i | sub_q;
endmodule

// File: rtl/fetch_req_slot.sv
// One-entry hold-off slot for requests that arrive mid-fetch.
module fetch_req_slot #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              can_start_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] start_addr_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;

  assign start_o      = can_start_i && (req_i || pend_q);
  assign start_addr_o = pend_q ? pend_addr_q : addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (start_o) begin
      // pending entry consumed; a same-cycle request takes its place
      pend_q <= pend_q && req_i;
      if (pend_q && req_i) pend_addr_q <= addr_i;
    end else if (req_i && !pend_q) begin
      pend_q      <= 1'b1;
      pend_addr_q <= addr_i;
    end
  end
endmodule

// File: rtl/fetch_seq_fsm.sv
module fetch_seq_fsm
  import fetch_seq_pkg::*;
#(
  parameter int ALE_STEPS    = 2,
  parameter int HOLD_STEPS   = 1,
  parameter int STROBE_STEPS = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         start_i,
  output fetch_state_e state_o,
  output logic         fetch_end_o
);
  localparam int MAX_STEPS = (ALE_STEPS > HOLD_STEPS) ?
                             ((ALE_STEPS > STROBE_STEPS) ? ALE_STEPS : STROBE_STEPS) :
                             ((HOLD_STEPS > STROBE_STEPS) ? HOLD_STEPS : STROBE_STEPS);
  localparam int CNT_W = $clog2(MAX_STEPS + 1);

  fetch_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_cnt;
  logic             step_done;

  always_comb begin
    unique case (state_q)
      ST_ALE:    last_cnt = CNT_W'(ALE_STEPS - 1);
      ST_HOLD:   last_cnt = CNT_W'(HOLD_STEPS - 1);
      ST_STROBE: last_cnt = CNT_W'(STROBE_STEPS - 1);
      default:   last_cnt = '0;
    endcase
  end

  assign step_done   = tick_i && (cnt_q == last_cnt) && (state_q != ST_IDLE);
  assign fetch_end_o = step_done && (state_q == ST_STROBE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (start_i) begin
      state_d = ST_ALE;
      cnt_d   = '0;
    end else if (step_done) begin
      cnt_d = '0;
      unique case (state_q)
        ST_ALE:    state_d = ST_HOLD;
        ST_HOLD:   state_d = ST_STROBE;
        default:   state_d = ST_IDLE;
      endcase
    end else if (tick_i && state_q != ST_IDLE) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_seq_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int ALE_STEPS    = 2,
  parameter int HOLD_STEPS   = 1,
  parameter int STROBE_STEPS = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     dbl_speed_i,
  input  logic [DATA_W-1:0]        bus_i,
  output logic [DATA_W-1:0]        bus_o,
  output logic                     bus_oe_o,
  output logic                     ale_o,
  output logic                     psen_no,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0]        instr_o,
  output logic                     done_o
);
  fetch_state_e      state;
  logic              tick, fetch_end, start, can_start, mode_q;
  logic [ADDR_W-1:0] start_addr, addr_q;
  logic [DATA_W-1:0] instr_q;
  logic              done_q;

  assign can_start = (state == ST_IDLE) || fetch_end;

  fetch_req_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .addr_i       (addr_i),
    .can_start_i  (can_start),
    .start_o      (start),
    .start_addr_o (start_addr)
  );

  fetch_tick_gen u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state != ST_IDLE),
    .restart_i (start),
    .dbl_i     (mode_q),
    .tick_o    (tick)
  );

  fetch_seq_fsm #(
    .ALE_STEPS    (ALE_STEPS),
    .HOLD_STEPS   (HOLD_STEPS),
    .STROBE_STEPS (STROBE_STEPS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .start_i     (start),
    .state_o     (state),
    .fetch_end_o (fetch_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      mode_q  <= 1'b0;
      instr_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (start) begin
        addr_q <= start_addr;
        mode_q <= dbl_speed_i;
      end
      if (fetch_end) instr_q <= bus_i;
      done_q <= fetch_end;
    end
  end

  assign ale_o     = (state == ST_ALE);
  assign bus_oe_o  = (state == ST_ALE) || (state == ST_HOLD);
  assign psen_no   = (state != ST_STROBE);
  assign bus_o     = addr_q[DATA_W-1:0];
  assign addr_hi_o = addr_q[ADDR_W-1:DATA_W];
  assign instr_o   = instr_q;
  assign done_o    = done_q;
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int HI_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ale_o,
  input logic            bus_oe_o,
  input logic            psen_no,
  input logic            done_o,
  input logic [HI_W-1:0] addr_hi_o
);
  AST_PSEN_NOT_WITH_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> !bus_oe_o && !ale_o); // R4

  AST_PSEN_FALL_RELEASES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psen_no) |-> $past(bus_oe_o) && !bus_oe_o); // R4

  AST_ADDR_HELD_AFTER_ALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> bus_oe_o); // R3

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5

  AST_DONE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> psen_no && !$past(psen_no)); // R5

  AST_ADDR_HI_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psen_no && !$past(psen_no)) |-> $stable(addr_hi_o)); // R6
endmodule

bind fetch_seq fetch_seq_chk #(.HI_W(ADDR_W - DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ale_o     (ale_o),
  .bus_oe_o  (bus_oe_o),
  .psen_no   (psen_no),
  .done_o    (done_o),
  .addr_hi_o (addr_hi_o)
);

// File: tb/fetch_seq_test.sv
`timescale 1ns/1ps
module fetch_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] addr = 16'h0;
  logic        dbl = 1'b0;
  logic [7:0]  bus_in;
  logic [7:0]  bus_out, addr_hi, instr;
  logic        bus_oe, ale, psen_n, done;
  logic [7:0]  lat_lo = 8'h0;
  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  fetch_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .dbl_speed_i(dbl),
    .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(bus_oe), .ale_o(ale), .psen_no(psen_n),
    .addr_hi_o(addr_hi), .instr_o(instr), .done_o(done)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] + a[15:8] * 8'd3 + 8'd1;
  endfunction

  // external memory: latches low byte on ALE fall, drives only while strobe low
  always @(negedge ale) lat_lo <= bus_out;
  assign bus_in = psen_n ? 8'hEE : mem_f({addr_hi, lat_lo});

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // compare outputs on clock k after acceptance; L = clocks per step
  task automatic check_cycle(input int k, input logic [15:0] a, input int L, input bit chk_done);
    bit e_ale, e_oe, e_psen_n, e_done;
    e_ale    = (k >= 1) && (k <= 2*L);
    e_oe     = (k >= 1) && (k <= 3*L);
    e_psen_n = !((k > 3*L) && (k <= 6*L));
    e_done   = (k == 6*L + 1);
    chk(ale == e_ale, $sformatf("R2 ale k=%0d", k), ale, e_ale);
    chk(bus_oe == e_oe, $sformatf("R3 oe k=%0d", k), bus_oe, e_oe);
    if (e_oe) chk(bus_out == a[7:0], $sformatf("R3 bus k=%0d", k), bus_out, a[7:0]);
    chk(psen_n == e_psen_n, $sformatf("R4 psen k=%0d", k), psen_n, e_psen_n);
    if (k >= 1 && k <= 6*L) chk(addr_hi == a[15:8], $sformatf("R6 hi k=%0d", k), addr_hi, a[15:8]);
    if (chk_done) begin
      chk(done == e_done, $sformatf("R5 done k=%0d", k), done, e_done);
      if (e_done) chk(instr == mem_f(a), "R5 instr", instr, mem_f(a));
    end
  endtask

  task automatic single_fetch(input logic [15:0] a, input bit m, input bit flip);
    int L;
    L = m ? 1 : 2;
    @(negedge clk);
    req = 1'b1; addr = a; dbl = m;
    @(negedge clk);
    req = 1'b0; addr = ~a;
    if (flip) dbl = ~m; // R8 mode change mid-fetch
    check_cycle(1, a, L, 1);
    for (int k = 2; k <= 6*L + 2; k++) begin
      @(negedge clk);
      check_cycle(k, a, L, 1);
      if (flip && k == 6*L + 1) chk(done == 1'b1, "R8 timing kept", done, 1);
    end
    chk(instr == mem_f(a), "R5 instr held", instr, mem_f(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    // R1 reset values
    #5;
    chk(ale == 0 && psen_n == 1 && bus_oe == 0 && done == 0, "R1 in reset",
        {ale, psen_n, bus_oe, done}, 4'b0100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ale == 0 && psen_n == 1 && bus_oe == 0 && done == 0, "R1 idle",
        {ale, psen_n, bus_oe, done}, 4'b0100);

    // sweep both modes over addresses including boundaries
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 8; i++)
        single_fetch(16'(i * 16'h2493) ^ (m[0] ? 16'hFFFF : 16'h0000), m[0], 1'b0);

    // R8: flip mode during fetch
    single_fetch(16'hBEEF, 1'b0, 1'b1);
    single_fetch(16'h1357, 1'b1, 1'b1);

    // R7: request while busy is held off, then starts back to back
    for (int m = 0; m < 2; m++) begin
      int L;
      logic [15:0] a, b;
      L = m[0] ? 1 : 2;
      a = 16'hC3A5 ^ 16'(m);
      b = 16'h5A11 + 16'(m);
      @(negedge clk);
      req = 1'b1; addr = a; dbl = m[0];
      @(negedge clk);
      req = 1'b0; addr = 16'h0;
      check_cycle(1, a, L, 1);
      for (int k = 2; k <= 6*L; k++) begin
        @(negedge clk);
        check_cycle(k, a, L, 1);
        if (k == 2) begin req = 1'b1; addr = b; end
        if (k == 3) begin req = 1'b0; addr = 16'hFFFF; end
      end
      @(negedge clk);
      chk(done == 1'b1, "R7 first done", done, 1);
      chk(instr == mem_f(a), "R7 first instr", instr, mem_f(a));
      chk(ale == 1'b1, "R7 next ale at 6L+1", ale, 1);
      check_cycle(1, b, L, 0);
      for (int k = 2; k <= 6*L + 2; k++) begin
        @(negedge clk);
        check_cycle(k, b, L, 1);
      end
    end

    repeat (4) @(negedge clk);
    chk(ale == 0 && psen_n == 1 && bus_oe == 0 && done == 0, "R1 idle at end",
        {ale, psen_n, bus_oe, done}, 4'b0100);
    finish_run();
  end
endmodule